// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block takes one free-running source clock and hands out a group of gated copies of it. An asynchronous, active-low stop input parks every gated copy. A per-output enable mask, held in a control register elsewhere, can switch off single outputs. Both controls are first brought into the source clock domain by a short flop chain. The gate itself is then changed only while the source clock is low. A stop therefore never cuts a high phase short, and a restart always begins with a complete high pulse.

A parameter picks the output style. In the differential style, every output has a true half and a complement half. One mask bit controls both halves of a pair. When the pair is parked, the true half sits low and the complement half sits high. In the single-ended style, the complement outputs are tied low. An ungated copy of the source clock is always provided, and neither the stop input nor the mask affects it.

A system uses one instance for a differential processor clock group and one for a single-ended bus clock group. Each instance has its own stop input. The other instance, and the free copy, keep running while one group is parked.

Top module: `clk_stop_gate`

## Requirements
- R1: `stopN` and every bit of `enMask` pass through `SYNC_STAGES` (default 2) flops clocked on rising edges of `srcClk`. Take a change first sampled at rising edge k. The high pulses that begin at edges k through k+SYNC_STAGES-1 are unaffected, and the change applies from the pulse at edge k+SYNC_STAGES. With the default, a stop therefore lets exactly 2 more pulses through, which is fewer than 4, and a release gives its first pulse at the second edge after sampling.
- R2: The gate state changes only on falling edges of `srcClk`. No gated true output is ever high while `srcClk` is low. Every high phase that a gated output produces, including the first one after a restart and the last one before a mask change, lasts the full source high phase.
- R3: While the synchronized stop is active (`stopN` = 0), every `clkT` bit is held at 0.
- R4: With `DIFF_OUT` = 1, every `clkC` bit is the inverse of the matching `clkT` bit. A parked pair therefore reads `clkT` = 0 and `clkC` = 1.
- R5: With `DIFF_OUT` = 0, every `clkC` bit is held at 0.
- R6: `enMask` bit i = 1 lets output i run, and bit i = 0 parks output i (both halves of the pair) exactly as a stop does. The other outputs are not affected.
- R7: `clkFree` follows `srcClk` at all times, whatever the values of `stopN`, `enMask` and `rstN`.
- R8: While `rstN` = 0 (asynchronous, active low), every gate is closed, so `clkT` = 0 and, with `DIFF_OUT` = 1, `clkC` = all ones. The synchronized mask resets to all enabled. After release, with `stopN` = 1 and `enMask` = all ones, all outputs run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Free-running source clock that is gated |
| rstN | input | 1 | Asynchronous active-low reset |
| stopN | input | 1 | Asynchronous active-low stop request for the whole group |
| enMask | input | NUM_OUT | Per-output enable, 1 = run, quasi-static register value |
| clkT | output | NUM_OUT | Gated true clock outputs |
| clkC | output | NUM_OUT | Complement outputs (differential style) or tied low |
| clkFree | output | 1 | Ungated copy of the source clock |

## Verification
Some properties are checked by assertions on every cycle. No gated true output may be high while the source clock is low. The complement outputs must sit at their parked level during the low phase. The free copy must follow the source. Once a stop, or an all-enabled run request, has been held for longer than the synchronizer depth, the gated outputs must be parked or all running. Other behaviour can only be shown by the bench's scenarios. These cover the exact pulse counts around a stop and a release, and the full width of a high pulse that is in flight when the mask changes. They also cover the separate effect of each mask bit and the single-ended variant.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic hold;   // synchronized group stop is active
  } gateCmd_t;

endpackage

// File: rtl/clk_stop_gate_ctrl.sv
`timescale 1ns/1ps
module clk_stop_gate_ctrl
  import clk_stop_gate_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               stopN,
  input  logic [NUM_OUT-1:0] enMask,
  output gateCmd_t           cmd,
  output logic [NUM_OUT-1:0] syncMask
);

  localparam int SYNC_W = NUM_OUT + 1;
  // After reset: stop level 0 (parked), mask all enabled (R8)
  localparam logic [SYNC_W-1:0] RST_VAL = {{NUM_OUT{1'b1}}, 1'b0};

  // Synchronizer chain carrying {mask, stop level} (R1)
  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stg
    logic [SYNC_W-1:0] q;
    if (k == 0) begin : g_first
      always_ff @(posedge srcClk or negedge rstN) begin
        if (!rstN) q <= RST_VAL;
        else       q <= {enMask, stopN};
      end
    end else begin : g_next
      always_ff @(posedge srcClk or negedge rstN) begin
        if (!rstN) q <= RST_VAL;
        else       q <= g_stg[k-1].q;
      end
    end
  end

  logic [SYNC_W-1:0] syncOut;
  assign syncOut  = g_stg[SYNC_STAGES-1].q;
  assign cmd.hold = ~syncOut[0];
  assign syncMask = syncOut[SYNC_W-1:1];

endmodule

// File: rtl/clk_stop_gate_dp.sv
`timescale 1ns/1ps
module clk_stop_gate_dp
  import clk_stop_gate_pkg::*;
#(
  parameter int NUM_OUT  = 4,
  parameter bit DIFF_OUT = 1'b1
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  gateCmd_t           cmd,
  input  logic [NUM_OUT-1:0] syncMask,
  output logic [NUM_OUT-1:0] clkT,
  output logic [NUM_OUT-1:0] clkC
);

  // Gate opens or closes only on the falling edge, while the source is low (R2)
  logic [NUM_OUT-1:0] gateQ;
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) gateQ <= '0;
    else       gateQ <= syncMask & {NUM_OUT{~cmd.hold}};
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign clkT[i] = srcClk & gateQ[i];
    if (DIFF_OUT) begin : g_diff
      assign clkC[i] = ~clkT[i];   // parked high while true half is low (R4)
    end else begin : g_single
      assign clkC[i] = 1'b0;       // R5
    end
  end

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter bit DIFF_OUT    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               stopN,
  input  logic [NUM_OUT-1:0] enMask,
  output logic [NUM_OUT-1:0] clkT,
  output logic [NUM_OUT-1:0] clkC,
  output logic               clkFree
);

  gateCmd_t           cmd;
  logic [NUM_OUT-1:0] syncMask;

  clk_stop_gate_ctrl #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .srcClk  (srcClk),
    .rstN    (rstN),
    .stopN   (stopN),
    .enMask  (enMask),
    .cmd     (cmd),
    .syncMask(syncMask)
  );

  clk_stop_gate_dp #(.NUM_OUT(NUM_OUT), .DIFF_OUT(DIFF_OUT)) u_dp (
    .srcClk  (srcClk),
    .rstN    (rstN),
    .cmd     (cmd),
    .syncMask(syncMask),
    .clkT    (clkT),
    .clkC    (clkC)
  );

  assign clkFree = srcClk;   // R7

endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int NUM_OUT     = 4,
  parameter bit DIFF_OUT    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input logic               srcClk,
  input logic               rstN,
  input logic               stopN,
  input logic [NUM_OUT-1:0] enMask,
  input logic [NUM_OUT-1:0] clkT,
  input logic [NUM_OUT-1:0] clkC,
  input logic               clkFree
);

  localparam int CW = $clog2(SYNC_STAGES + 2) + 1;
  localparam logic [CW-1:0] LIM = CW'(SYNC_STAGES + 1);

  // Rising edges in a row with stop held, and with an all-enabled run request
  logic [CW-1:0] stopCnt, runCnt;
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      stopCnt <= '0;
      runCnt  <= '0;
    end else begin
      if (!stopN) stopCnt <= (stopCnt < LIM) ? stopCnt + 1'b1 : stopCnt;
      else        stopCnt <= '0;
      if (stopN && (&enMask)) runCnt <= (runCnt < LIM) ? runCnt + 1'b1 : runCnt;
      else                    runCnt <= '0;
    end
  end

  // Values sampled just before a rising edge belong to the low phase
  assert_low_phase_R2: assert property (@(posedge srcClk) disable iff (!rstN)
    clkT == '0);

  // Values sampled just before a falling edge belong to the high phase
  assert_parked_R3: assert property (@(negedge srcClk) disable iff (!rstN)
    (stopCnt >= LIM) |-> (clkT == '0));

  assert_running_R1: assert property (@(negedge srcClk) disable iff (!rstN)
    (runCnt >= LIM) |-> (clkT == '1));

  assert_free_high_R7: assert property (@(negedge srcClk) disable iff (!rstN)
    clkFree == 1'b1);

  if (DIFF_OUT) begin : g_diffChk
    assert_comp_park_R4: assert property (@(posedge srcClk) disable iff (!rstN)
      clkC == '1);
  end else begin : g_singleChk
    assert_comp_low_R5: assert property (@(posedge srcClk) disable iff (!rstN)
      clkC == '0);
  end

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .NUM_OUT(NUM_OUT), .DIFF_OUT(DIFF_OUT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .srcClk(srcClk), .rstN(rstN), .stopN(stopN), .enMask(enMask),
  .clkT(clkT), .clkC(clkC), .clkFree(clkFree)
);

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/1ps
module clk_stop_gate_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stopN = 1'b1;
  logic [3:0] enMask = 4'hF;
  logic [3:0] cpuT, cpuC;
  logic       cpuFree;
  logic [5:0] pciT, pciC;
  logic       pciFree;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  clk_stop_gate u_clk_stop_gate (
    .srcClk(clk), .rstN(rstN), .stopN(stopN), .enMask(enMask),
    .clkT(cpuT), .clkC(cpuC), .clkFree(cpuFree)
  );

  clk_stop_gate #(.NUM_OUT(6), .DIFF_OUT(1'b0)) u_pci (
    .srcClk(clk), .rstN(rstN), .stopN(stopN), .enMask(6'h3F),
    .clkT(pciT), .clkC(pciC), .clkFree(pciFree)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {stopN, enMask, expected clkT}
  localparam int NV = 7;
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 4'hF, 4'hF},
    {1'b1, 4'h5, 4'h5},
    {1'b0, 4'hF, 4'h0},
    {1'b1, 4'hA, 4'hA},
    {1'b1, 4'h0, 4'h0},
    {1'b0, 4'h3, 4'h0},
    {1'b1, 4'hF, 4'hF}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    // Reset state (R8, R7)
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset clkT", {4'h0, cpuT}, 8'h00);
    chk("R8 reset clkC", {4'h0, cpuC}, 8'h0F);
    chk("R7 free in reset", {7'h0, cpuFree}, 8'h01);
    @(negedge clk); #0.5;
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R8 run after reset", {4'h0, cpuT}, 8'h0F);

    // Vector table walk (R3, R4, R5, R6, R7)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); #0.5;
      stopN  = VEC[v][8];
      enMask = VEC[v][7:4];
      repeat (4) @(posedge clk);
      @(posedge clk); #1;
      chk("R6 R3 high phase clkT", {4'h0, cpuT}, {4'h0, VEC[v][3:0]});
      chk("R4 high phase clkC", {4'h0, cpuC}, {4'h0, ~VEC[v][3:0]});
      chk("R5 single clkT", {2'b0, pciT}, VEC[v][8] ? 8'h3F : 8'h00);
      chk("R5 single clkC", {2'b0, pciC}, 8'h00);
      chk("R7 free high", {6'h0, pciFree, cpuFree}, 8'h03);
      @(negedge clk); #1;
      chk("R2 low phase clkT", {4'h0, cpuT}, 8'h00);
      chk("R4 low phase clkC", {4'h0, cpuC}, 8'h0F);
      chk("R7 free low", {6'h0, pciFree, cpuFree}, 8'h00);
    end

    // Stop latency: two more pulses, then parked (R1, R3)
    @(negedge clk); #0.5;
    stopN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R1 stop latency", {7'h0, cpuT[0]}, (i < 2) ? 8'h01 : 8'h00);
    end
    repeat (3) @(posedge clk);

    // Release latency and full first pulse (R1, R2)
    @(negedge clk); #0.5;
    stopN = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1.8;
      chk("R1 release still parked", {7'h0, cpuT[0]}, 8'h00);
    end
    @(posedge clk); #0.2;
    chk("R2 first pulse start", {7'h0, cpuT[0]}, 8'h01);
    #1.6;
    chk("R2 first pulse end", {7'h0, cpuT[0]}, 8'h01);
    @(posedge clk); #1;
    chk("R1 release running", {7'h0, cpuT[0]}, 8'h01);

    // Mask cleared mid high phase: pulse completes, bit 0 parks later (R2, R6)
    @(posedge clk); #1;
    enMask = 4'hE;
    #0.8;
    chk("R2 in-flight pulse kept", {7'h0, cpuT[0]}, 8'h01);
    @(posedge clk); #1;
    chk("R6 mask latency 1", {7'h0, cpuT[0]}, 8'h01);
    @(posedge clk); #1.8;
    chk("R6 mask latency 2 full", {7'h0, cpuT[0]}, 8'h01);
    @(posedge clk); #1;
    chk("R6 bit0 parked", {4'h0, cpuT}, 8'h0E);
    chk("R6 pair both halves", {7'h0, cpuC[0]}, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule